// File: doc/BRIEF.md
# Replay-Protected Authenticated Write Controller

This block sits in front of a small protected storage partition and decides whether a host request may touch it. The host streams a fixed 512-byte request frame into the block one byte per accepted cycle, most significant byte first. The block pulls out the request kind, the write counter, the block address, the block count, the 256-byte payload and the 32-byte tag. Unauthenticated reads and counter queries are answered directly. A write is first checked against the stored monotonic counter and the partition size. Only then does the block ask an external keyed-hash engine for the tag that a genuine host would have produced. That tag is compared with the received one over its full length.

A write is committed only when every check passes. The payload goes out on the storage port, and the stored counter takes the frame's counter value, both on the same clock edge. Any failure leaves both the storage and the counter untouched and returns a result code. The block takes no new frame until it has issued its response. The hash engine, key handling and the storage medium are external.

Top module: `auth_wr_ctrl`

## Requirements
- R1: A frame is 512 bytes sent most significant byte first, with byte offsets tag 196–227, payload 228–483, counter 500–503 (big-endian), address 504–505, block count 506–507 and request kind 510–511. Every other byte is ignored. `in_ready` is low from the cycle after the last byte is taken until the response cycle has passed.
- R2: A frame of kind 2 (counter query) returns response kind 0x0200, result 0 and the current stored counter on `rsp_counter`.
- R3: A frame of kind 3 (write) whose counter is not strictly greater than the stored counter returns result 3. It makes no hash request and no storage write, and it leaves the counter unchanged.
- R4: Once the stored counter equals 0xFFFFFFFF, every write returns result 3 and the counter stays at 0xFFFFFFFF.
- R5: A write or read whose address is at or above `PART_BLOCKS` returns result 4 with no hash request, storage access or counter change. For a write, the counter check comes first.
- R6: A write that passes the counter and address checks raises `mac_start` for exactly one cycle. The counter, address, block count and payload of the frame are presented on the `mac_*` outputs. The block then waits for `mac_done`.
- R7: If the returned tag differs from the received tag in any bit, the response carries result 2, nothing is written and the counter is unchanged.
- R8: If the tags match, `st_wr_en` rises for one cycle with the payload and address. On that same edge the stored counter becomes the frame counter. The response is kind 0x0300, result 0, and it reports the new counter.
- R9: A frame of kind 4 (read) with a valid address needs no tag. It reads the block, and the response is kind 0x0400, result 0, with the block data on `rsp_data` and the address on `rsp_addr`.
- R10: Any other request kind, including 1 (key programming), returns result 1. The response kind is always the request kind shifted left by 8.
- R11: `rsp_valid` is a single-cycle pulse. After reset the counter is 0, `in_ready` is high and no response, hash request or storage access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block can take a frame byte |
| mac_start | output | 1 | One-cycle request to the hash engine |
| mac_ctr | output | 32 | Counter field for the hash message |
| mac_addr | output | 16 | Address field for the hash message |
| mac_bcnt | output | 16 | Block-count field for the hash message |
| mac_data | output | 2048 | Payload for the hash message |
| mac_done | input | 1 | Hash engine result valid |
| mac_tag | input | 256 | Expected tag from the hash engine |
| st_wr_en | output | 1 | Storage write strobe |
| st_rd_en | output | 1 | Storage read strobe, data due next cycle |
| st_addr | output | 16 | Storage block address |
| st_wdata | output | 2048 | Storage write data |
| st_rdata | input | 2048 | Storage read data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_type | output | 16 | Response kind |
| rsp_result | output | 16 | Result code |
| rsp_counter | output | 32 | Stored counter value |
| rsp_addr | output | 16 | Address of the request |
| rsp_data | output | 2048 | Read data, zero otherwise |

## Verification
Two functions fall on one clock edge: the storage write and the counter update. Both happen in the cycle where a matching tag arrives. The bench provokes this with a genuine write frame and a hash-engine model that returns the matching tag a few cycles after the request. Its storage model records the write strobe in that cycle. The bench then judges the commit from the response counter and a later counter query, which must show the new value. Replayed, stale, out-of-range and bad-tag frames must show neither the write nor the counter change.

// File: rtl/arw_pkg.sv
`timescale 1ns/1ps
package arw_pkg;
  localparam int FRAME_BYTES = 512;
  localparam int DATA_BYTES  = 256;
  localparam int TAG_BYTES   = 32;
  localparam int DATA_W      = DATA_BYTES * 8;
  localparam int TAG_W       = TAG_BYTES * 8;
  localparam int CTR_W       = 32;
  localparam int ADDR_W      = 16;
  localparam int KIND_W      = 16;

  // byte offsets inside the frame (first byte on the wire is offset 0)
  localparam int OFS_TAG  = 196;
  localparam int OFS_DATA = OFS_TAG + TAG_BYTES;
  localparam int OFS_CTR  = 500;
  localparam int OFS_ADDR = OFS_CTR + CTR_W / 8;
  localparam int OFS_BCNT = OFS_ADDR + ADDR_W / 8;
  localparam int OFS_KIND = 510;

  localparam logic [KIND_W-1:0] KIND_CTRQ  = 16'd2;
  localparam logic [KIND_W-1:0] KIND_WRITE = 16'd3;
  localparam logic [KIND_W-1:0] KIND_READ  = 16'd4;

  typedef enum logic [15:0] {
    RES_OK   = 16'd0,
    RES_GEN  = 16'd1,
    RES_AUTH = 16'd2,
    RES_CTR  = 16'd3,
    RES_ADDR = 16'd4
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HREQ, S_HWAIT, S_RDREQ, S_RDCAP, S_RESP
  } state_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [CTR_W-1:0]  ctr;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       bcnt;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/arw_frame_rx.sv
`timescale 1ns/1ps
module arw_frame_rx
  import arw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       release_i,
  output logic       in_ready,
  output logic       full_o,
  output frame_t     frm_o
);
  // only bytes from the tag onwards are kept; the rest fall off the window
  localparam int WIN_BYTES = FRAME_BYTES - OFS_TAG;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int CNT_W     = $clog2(FRAME_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);

  function automatic int msb_of(input int ofs);
    return WIN_W - 1 - 8 * (ofs - OFS_TAG);
  endfunction

  localparam int P_TAG  = msb_of(OFS_TAG);
  localparam int P_DATA = msb_of(OFS_DATA);
  localparam int P_CTR  = msb_of(OFS_CTR);
  localparam int P_ADDR = msb_of(OFS_ADDR);
  localparam int P_BCNT = msb_of(OFS_BCNT);
  localparam int P_KIND = msb_of(OFS_KIND);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             take;

  assign take = in_valid && !full_q;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (take) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (release_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  // data path window, no reset needed
  always_ff @(posedge clk) begin
    if (take) win_q <= {win_q[WIN_W-9:0], in_data};
  end

  assign in_ready    = !full_q;
  assign full_o      = full_q;
  assign frm_o.tag   = win_q[P_TAG  -: TAG_W];
  assign frm_o.data  = win_q[P_DATA -: DATA_W];
  assign frm_o.ctr   = win_q[P_CTR  -: CTR_W];
  assign frm_o.addr  = win_q[P_ADDR -: ADDR_W];
  assign frm_o.bcnt  = win_q[P_BCNT -: 16];
  assign frm_o.kind  = win_q[P_KIND -: KIND_W];

  p_count_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (cnt_q == '0));
  p_frame_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !release_i) |=> (full_q && $stable(win_q)));
endmodule

// File: rtl/arw_tag_cmp.sv
`timescale 1ns/1ps
module arw_tag_cmp #(
  parameter int W      = 256,
  parameter int WORD_W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  localparam int WORDS = W / WORD_W;
  logic [WORDS-1:0] word_ne;

  // every word is compared; the verdict only exists after all of them
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign word_ne[g] = |(a_i[g*WORD_W +: WORD_W] ^ b_i[g*WORD_W +: WORD_W]);
  end

  assign eq_o = ~|word_ne;
endmodule

// File: rtl/arw_ctr_store.sv
`timescale 1ns/1ps
module arw_ctr_store #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit_i,
  input  logic [W-1:0] new_i,
  output logic [W-1:0] val_o,
  output logic         at_max_o
);
  logic [W-1:0] ctr_q, ctr_d;

  always_comb begin
    ctr_d = ctr_q;
    if (commit_i) ctr_d = new_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

  assign val_o    = ctr_q;
  assign at_max_o = &ctr_q;

  p_commit_greater_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (new_i > ctr_q));
  p_ctr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(ctr_q));
  p_ctr_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (ctr_q == $past(new_i)));
  p_max_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    at_max_o |=> at_max_o);
endmodule

// File: rtl/auth_wr_ctrl.sv
`timescale 1ns/1ps
module auth_wr_ctrl
  import arw_pkg::*;
#(
  parameter int PART_BLOCKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              mac_start,
  output logic [CTR_W-1:0]  mac_ctr,
  output logic [ADDR_W-1:0] mac_addr,
  output logic [15:0]       mac_bcnt,
  output logic [DATA_W-1:0] mac_data,
  input  logic              mac_done,
  input  logic [TAG_W-1:0]  mac_tag,
  output logic              st_wr_en,
  output logic              st_rd_en,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_wdata,
  input  logic [DATA_W-1:0] st_rdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_type,
  output logic [15:0]       rsp_result,
  output logic [CTR_W-1:0]  rsp_counter,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [ADDR_W:0] PART_LIM = (ADDR_W + 1)'(PART_BLOCKS);

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  frame_t            frm;
  logic              full, release_rx;
  logic              tag_eq, commit;
  logic [CTR_W-1:0]  ctr_val;
  logic              ctr_at_max, addr_bad;
  state_e            state_q, state_d;
  res_e              res_q, res_d;
  logic              res_en, dat_en;
  logic [DATA_W-1:0] dat_q, dat_d;

  arw_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .release_i (release_rx),
    .in_ready  (in_ready),
    .full_o    (full),
    .frm_o     (frm)
  );

  arw_tag_cmp #(.W(TAG_W), .WORD_W(32)) u_cmp (
    .a_i  (mac_tag),
    .b_i  (frm.tag),
    .eq_o (tag_eq)
  );

  arw_ctr_store #(.W(CTR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .commit_i (commit),
    .new_i    (frm.ctr),
    .val_o    (ctr_val),
    .at_max_o (ctr_at_max)
  );

  assign addr_bad = ({1'b0, frm.addr} >= PART_LIM);
  // data and counter move on one edge, only from the tag-match path
  assign commit   = (state_q == S_HWAIT) && mac_done && tag_eq;

  always_comb begin
    state_d    = state_q;
    res_d      = res_q;
    res_en     = 1'b0;
    dat_d      = '0;
    dat_en     = 1'b0;
    release_rx = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (full) begin
          res_en = 1'b1;
          dat_en = 1'b1;
          res_d  = RES_OK;
          state_d = S_RESP;
          case (frm.kind)
            KIND_CTRQ: ;
            KIND_WRITE: begin
              if (ctr_at_max || (frm.ctr <= ctr_val)) res_d = RES_CTR;
              else if (addr_bad)                      res_d = RES_ADDR;
              else                                    state_d = S_HREQ;
            end
            KIND_READ: begin
              if (addr_bad) res_d = RES_ADDR;
              else          state_d = S_RDREQ;
            end
            default: res_d = RES_GEN;
          endcase
        end
      end
      S_HREQ:  state_d = S_HWAIT;
      S_HWAIT: begin
        if (mac_done) begin
          res_en  = 1'b1;
          res_d   = tag_eq ? RES_OK : RES_AUTH;
          state_d = S_RESP;
        end
      end
      S_RDREQ: state_d = S_RDCAP;
      S_RDCAP: begin
        dat_en  = 1'b1;
        dat_d   = st_rdata;
        state_d = S_RESP;
      end
      S_RESP: begin
        release_rx = 1'b1;
        state_d    = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      if (res_en) res_q <= res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= dat_d;
  end

  assign mac_start   = (state_q == S_HREQ);
  assign mac_ctr     = frm.ctr;
  assign mac_addr    = frm.addr;
  assign mac_bcnt    = frm.bcnt;
  assign mac_data    = frm.data;
  assign st_wr_en    = commit;
  assign st_rd_en    = (state_q == S_RDREQ);
  assign st_addr     = frm.addr;
  assign st_wdata    = frm.data;
  assign rsp_valid   = (state_q == S_RESP);
  assign rsp_type    = {frm.kind[7:0], 8'h00};
  assign rsp_result  = res_q;
  assign rsp_counter = ctr_val;
  assign rsp_addr    = frm.addr;
  assign rsp_data    = dat_q;

  p_busy_stall_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != S_IDLE) |-> !in_ready);
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    mac_start |=> !mac_start);
  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    st_wr_en |-> ({1'b0, st_addr} < PART_LIM));
  p_write_then_ok_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    st_wr_en |=> (rsp_valid && rsp_result == 16'd0));
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |=> !rsp_valid);
  p_no_rw_overlap_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(st_rd_en && st_wr_en));
endmodule

// File: tb/auth_wr_ctrl_test.sv
`timescale 1ns/1ps
module auth_wr_ctrl_test;
  import arw_pkg::*;
  localparam int PB = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, in_valid, in_ready, mac_start, mac_done;
  logic [7:0]        in_data;
  logic [CTR_W-1:0]  mac_ctr, rsp_counter;
  logic [ADDR_W-1:0] mac_addr, st_addr, rsp_addr;
  logic [15:0]       mac_bcnt, rsp_type, rsp_result;
  logic [DATA_W-1:0] mac_data, st_wdata, st_rdata, rsp_data;
  logic [TAG_W-1:0]  mac_tag;
  logic              st_wr_en, st_rd_en, rsp_valid;

  auth_wr_ctrl #(.PART_BLOCKS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mac_start(mac_start), .mac_ctr(mac_ctr),
    .mac_addr(mac_addr), .mac_bcnt(mac_bcnt), .mac_data(mac_data),
    .mac_done(mac_done), .mac_tag(mac_tag), .st_wr_en(st_wr_en),
    .st_rd_en(st_rd_en), .st_addr(st_addr), .st_wdata(st_wdata),
    .st_rdata(st_rdata), .rsp_valid(rsp_valid), .rsp_type(rsp_type),
    .rsp_result(rsp_result), .rsp_counter(rsp_counter),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mkdata(input int seed);
    logic [DATA_W-1:0] d;
    for (int j = 0; j < DATA_BYTES; j++) d[DATA_W-1-8*j -: 8] = 8'(seed * 37 + j);
    return d;
  endfunction

  // stand-in keyed hash: any fixed mix of the four message fields
  function automatic logic [TAG_W-1:0] tagf(input logic [31:0] c, input logic [15:0] a,
                                            input logic [15:0] b, input logic [DATA_W-1:0] d);
    return {c, a, b, 192'h0} ^ d[DATA_W-1 -: TAG_W] ^ d[TAG_W-1:0] ^ {8{c ^ 32'h5a5a_0f0f}};
  endfunction

  // external engine and storage models
  logic [DATA_W-1:0] mem [0:PB-1];
  int n_start = 0, n_wr = 0, n_rd = 0, hcnt = 0;
  logic [31:0] c_ctr; logic [15:0] c_addr, c_bcnt; logic [DATA_W-1:0] c_data;

  initial begin
    for (int i = 0; i < PB; i++) mem[i] = '0;
    mac_done = 1'b0; mac_tag = '0; st_rdata = '0;
    forever begin
      @(negedge clk);
      if (mac_done) mac_done = 1'b0;
      if (hcnt > 0) begin
        hcnt--;
        if (hcnt == 0) begin
          mac_done = 1'b1;
          mac_tag  = tagf(c_ctr, c_addr, c_bcnt, c_data);
        end
      end
      #1;
      if (mac_start) begin
        n_start++;
        c_ctr = mac_ctr; c_addr = mac_addr; c_bcnt = mac_bcnt; c_data = mac_data;
        hcnt = 3;
      end
      if (st_wr_en) begin
        n_wr++;
        if (int'(st_addr) < PB) mem[int'(st_addr)] = st_wdata;
      end
      if (st_rd_en) begin
        n_rd++;
        if (int'(st_addr) < PB) st_rdata = mem[int'(st_addr)];
      end
    end
  end

  function automatic logic [7:0] fbyte(input int k, input logic [15:0] kind,
      input logic [31:0] c, input logic [15:0] a, input logic [15:0] b,
      input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    if (k >= 196 && k < 228) return t[TAG_W-1-8*(k-196) -: 8];
    if (k >= 228 && k < 484) return d[DATA_W-1-8*(k-228) -: 8];
    if (k >= 500 && k < 504) return c[31-8*(k-500) -: 8];
    if (k >= 504 && k < 506) return a[15-8*(k-504) -: 8];
    if (k >= 506 && k < 508) return b[15-8*(k-506) -: 8];
    if (k >= 510)            return kind[15-8*(k-510) -: 8];
    return 8'hA5;  // stuff, nonce and result bytes: ignored (R1)
  endfunction

  logic [DATA_W-1:0] last_data;
  logic [15:0]       last_addr;

  task automatic run_req(input string tg, input logic [15:0] kind, input logic [31:0] c,
                         input logic [15:0] a, input bit good, input int seed,
                         input logic [15:0] eres, input logic [31:0] ectr);
    logic [DATA_W-1:0] d;
    logic [TAG_W-1:0]  t;
    int s0, w0, r0, guard;
    bit exp_h, exp_w, exp_r;
    d = mkdata(seed);
    t = tagf(c, a, 16'd1, d);
    if (!good) t[0] = ~t[0];
    s0 = n_start; w0 = n_wr; r0 = n_rd;
    for (int k = 0; k < FRAME_BYTES; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbyte(k, kind, c, a, 16'd1, t, d);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, {tg, " R1 busy after last byte"}, 64'(in_ready), 64'd0);
    guard = 0;
    while (!rsp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid == 1'b1, {tg, " response arrives"}, 64'(rsp_valid), 64'd1);
    chk(rsp_type == {kind[7:0], 8'h00}, {tg, " R10 response kind"}, 64'(rsp_type),
        64'({kind[7:0], 8'h00}));
    chk(rsp_result == eres, {tg, " result code"}, 64'(rsp_result), 64'(eres));
    chk(rsp_counter == ectr, {tg, " counter"}, 64'(rsp_counter), 64'(ectr));
    last_data = rsp_data;
    last_addr = rsp_addr;
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tg, " R11 single pulse"}, 64'(rsp_valid), 64'd0);
    exp_h = (kind == 16'd3) && (eres == 16'd0 || eres == 16'd2);
    exp_w = (kind == 16'd3) && (eres == 16'd0);
    exp_r = (kind == 16'd4) && (eres == 16'd0);
    chk((n_start - s0) == int'(exp_h), {tg, " R6 hash requests (R3 counter first)"},
        64'(n_start - s0), 64'(exp_h));
    chk((n_wr - w0) == int'(exp_w), {tg, " R8 storage writes"}, 64'(n_wr - w0), 64'(exp_w));
    chk((n_rd - r0) == int'(exp_r), {tg, " R5 storage reads"}, 64'(n_rd - r0), 64'(exp_r));
    if (exp_h) begin
      chk(c_ctr == c && c_addr == a && c_bcnt == 16'd1, {tg, " R6 hash fields"},
          {c_ctr, c_addr, c_bcnt}, {c, a, 16'd1});
      chk(c_data == d, {tg, " R6 hash payload"}, c_data[63:0], d[63:0]);
    end
    if (exp_w)
      chk(mem[int'(a)] == d, {tg, " R8 stored payload"}, mem[int'(a)][63:0], d[63:0]);
  endtask

  typedef struct packed {
    logic [15:0] kind;
    logic [31:0] ctr;
    logic [15:0] addr;
    logic        good;
    logic [15:0] eres;
    logic [31:0] ectr;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{16'd2, 32'd0, 16'd0,  1'b1, 16'd0, 32'd0},  // R2 query at reset value
    '{16'd3, 32'd5, 16'd3,  1'b1, 16'd0, 32'd5},  // R8 good write
    '{16'd3, 32'd5, 16'd3,  1'b1, 16'd3, 32'd5},  // R3 exact replay
    '{16'd3, 32'd4, 16'd3,  1'b1, 16'd3, 32'd5},  // R3 stale counter
    '{16'd3, 32'd6, 16'd3,  1'b0, 16'd2, 32'd5},  // R7 tag mismatch
    '{16'd3, 32'd6, 16'd64, 1'b1, 16'd4, 32'd5},  // R5 address at limit
    '{16'd2, 32'd0, 16'd0,  1'b1, 16'd0, 32'd5},  // R2 query after write
    '{16'd1, 32'd9, 16'd0,  1'b1, 16'd1, 32'd5},  // R10 key programming
    '{16'd9, 32'd9, 16'd0,  1'b1, 16'd1, 32'd5},  // R10 unknown kind
    '{16'd3, 32'd7, 16'd0,  1'b1, 16'd0, 32'd7},  // R8 second write
    '{16'd4, 32'd0, 16'd64, 1'b1, 16'd4, 32'd7}   // R5 read out of range
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 reset in_ready", 64'(in_ready), 64'd1);
    chk(rsp_valid == 1'b0 && mac_start == 1'b0, "R11 reset idle outputs",
        64'({rsp_valid, mac_start}), 64'd0);
    chk(st_wr_en == 1'b0 && st_rd_en == 1'b0, "R11 reset storage idle",
        64'({st_wr_en, st_rd_en}), 64'd0);

    for (int i = 0; i < 11; i++)
      run_req($sformatf("vec%0d", i), VEC[i].kind, VEC[i].ctr, VEC[i].addr,
              VEC[i].good, i, VEC[i].eres, VEC[i].ectr);

    // R9 unauthenticated read returns what vector 1 wrote
    run_req("R9 read", 16'd4, 32'd0, 16'd3, 1'b0, 0, 16'd0, 32'd7);
    chk(last_data == mkdata(1), "R9 read data", last_data[63:0], mkdata(1)[63:0]);
    chk(last_addr == 16'd3, "R9 read address", 64'(last_addr), 64'd3);

    // R4 counter reaches its ceiling, then every write is refused
    run_req("R4 to max", 16'd3, 32'hFFFF_FFFF, 16'd2, 1'b1, 20, 16'd0, 32'hFFFF_FFFF);
    run_req("R4 refused", 16'd3, 32'hFFFF_FFFF, 16'd2, 1'b1, 21, 16'd3, 32'hFFFF_FFFF);
    run_req("R4 query", 16'd2, 32'd0, 16'd0, 1'b1, 0, 16'd0, 32'hFFFF_FFFF);
    chk(mem[2] == mkdata(20), "R4 block kept", mem[2][63:0], mkdata(20)[63:0]);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule